// File: doc/BRIEF.md
# SIMD Widening Add/Subtract Unit

This unit decodes and executes the widening three-register integer operations of a SIMD engine whose register file holds 64-bit registers. There are four operations, and each comes in a signed and an unsigned form:

- long add and long subtract, where both sources are narrow and both are widened;
- wide add and wide subtract, where the first source is already a wide register pair and only the second source is widened.

Each element of 8, 16 or 32 bits is extended to twice its width. The extension is a sign extension or a zero extension, chosen by the instruction. The lanes are then added or subtracted independently of one another.

A controller pulses `start_i` with an instruction word. The unit reads its operands through two register read ports and then writes two 64-bit results, one at a time, through a single write port. The results go to an even/odd destination pair. The unit then pulses `done_o`.

All operands for both passes are captured before the first result is written. A destination pair that overlaps a source therefore still gives the result computed from the original register contents.

The unit rejects an illegal encoding with `undef_o` and writes nothing. An input tells the unit that the floating-point/SIMD unit is disabled. In that case a legal instruction ends with `fault_o`, also without a write.

Top module: `simd_widen_unit`

## Requirements
- R1: An instruction word is accepted only when all of the following hold: bits [31:25] = 1111001, bit 23 = 1, bits [11:10] = 00, bit 6 = 0 and bit 4 = 0. Any other word ends with `undef_o`.
- R2: A size field (bits [21:20]) of 11 ends with `undef_o`. Codes 00, 01 and 10 select 8-, 16- and 32-bit elements.
- R3: The destination index is {bit 22, bits [15:12]}. The first source index is {bit 7, bits [19:16]}. An odd destination index ends with `undef_o`. In the wide forms, an odd first source index also ends with `undef_o`.
- R4: The second source index is {bit 5, bits [3:0]}. When `regs32_i` is 0, any of the three indices at 16 or above ends with `undef_o`.
- R5: Bit 24 = 1 selects zero extension and 0 selects sign extension. Each result lane is the widened first element plus or minus the widened second element, modulo the lane width, with no carry or borrow crossing lanes.
- R6: In the wide forms, the first operand is register Vn for pass 0 and Vn+1 for pass 1, used unmodified. In the long forms, it is the low half (pass 0) or high half (pass 1) of Vn. The second operand is always the low or high half of Vm.
- R7: Bits [9:8] select the operation: 00 long add, 01 wide add, 10 long subtract, 11 wide subtract.
- R8: A legal instruction writes Vd on the 3rd clock edge after the start edge and Vd+1 on the 4th. `done_o` is high for exactly one cycle, following the 4th edge. No other register is written.
- R9: Results are computed from the register contents before the instruction began, even when Vd or Vd+1 equals Vn, Vn+1 or Vm.
- R10: An undefined instruction raises `undef_o` together with `done_o` in the cycle after the start edge. No write is made.
- R11: If `fp_en_i` is 0, a legal instruction raises `fault_o` with `done_o` in the cycle after the start edge. No write is made. `undef_o` takes priority over `fault_o`.
- R12: `start_i` is ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; the instruction is sampled with it |
| insn_i | input | 32 | Instruction word |
| regs32_i | input | 1 | 1 = 32 registers exist, 0 = only 16 |
| fp_en_i | input | 1 | SIMD unit enabled |
| rd_a_idx_o | output | 5 | Read port A index (first source) |
| rd_a_data_i | input | 64 | Read port A data, same cycle |
| rd_b_idx_o | output | 5 | Read port B index (second source) |
| rd_b_data_i | input | 64 | Read port B data, same cycle |
| we_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Write index |
| wr_data_o | output | 64 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | Undefined instruction, valid with done_o |
| fault_o | output | 1 | Unit disabled, valid with done_o |

## Verification
The hardest situation to reach is a destination pair that aliases a source that is still needed for the second pass. The clearest case is a long form with Vd equal to Vn or Vm, where the high half has to survive the first write.

The bench builds instruction words directly from chosen index values. It forces Vd onto Vn, onto Vm, and Vd+1 onto Vm. The expected values come from a snapshot of the register file taken before the start pulse.

Legal and illegal encodings are reached by a sweep over every sign/operation/size combination with random indices. On top of that sweep come single-bit corruptions of each fixed opcode bit and runs in 16-register mode.

// File: rtl/simd_widen_pkg.sv
package simd_widen_pkg;
  localparam int unsigned REG_W = 64;
  localparam int unsigned IDX_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_WR0, ST_WR1, ST_DONE
  } state_e;

  typedef struct packed {
    logic             undef;
    logic             uns;
    logic             sub;
    logic             wide;
    logic [1:0]       size;
    logic [IDX_W-1:0] vd;
    logic [IDX_W-1:0] vn;
    logic [IDX_W-1:0] vm;
  } dec_t;
endpackage

// File: rtl/simd_widen_decode.sv
module simd_widen_decode
  import simd_widen_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        regs32_i,
  output dec_t        dec_o
);
  logic match, bad_size, bad_align, bad_range;

  always_comb begin
    dec_o.uns  = insn_i[24];
    dec_o.size = insn_i[21:20];
    dec_o.wide = insn_i[8];
    dec_o.sub  = insn_i[9];
    dec_o.vd   = {insn_i[22], insn_i[15:12]};
    dec_o.vn   = {insn_i[7],  insn_i[19:16]};
    dec_o.vm   = {insn_i[5],  insn_i[3:0]};

    match     = (insn_i[31:25] == 7'b1111001) && insn_i[23] &&
                (insn_i[11:10] == 2'b00) && !insn_i[6] && !insn_i[4];
    bad_size  = (dec_o.size == 2'b11);
    bad_align = dec_o.vd[0] || (dec_o.wide && dec_o.vn[0]);
    bad_range = !regs32_i &&
                (dec_o.vd[IDX_W-1] || dec_o.vn[IDX_W-1] || dec_o.vm[IDX_W-1]);

    dec_o.undef = !match || bad_size || bad_align || bad_range;
  end
endmodule

// File: rtl/simd_widen_alu.sv
module simd_widen_alu #(
  parameter int unsigned W     = 64,
  parameter int unsigned MIN_E = 8
) (
  input  logic [W-1:0]   a_wide_i,
  input  logic [W/2-1:0] a_nar_i,
  input  logic [W/2-1:0] b_nar_i,
  input  logic [1:0]     size_i,
  input  logic           uns_i,
  input  logic           sub_i,
  input  logic           wide_i,
  output logic [W-1:0]   res_o
);
  localparam int unsigned H   = W / 2;
  localparam int unsigned NSZ = $clog2(H / MIN_E) + 1;

  logic [W-1:0] res_v [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int unsigned E  = MIN_E << s;
    localparam int unsigned NL = H / E;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      logic [E-1:0]   an, bn;
      logic [2*E-1:0] ax, bx;
      assign an = a_nar_i[l*E +: E];
      assign bn = b_nar_i[l*E +: E];
      assign bx = {{E{~uns_i & bn[E-1]}}, bn};
      assign ax = wide_i ? a_wide_i[l*2*E +: 2*E] : {{E{~uns_i & an[E-1]}}, an};
      // lane-local arithmetic: carries stop at the lane edge
      assign res_v[s][l*2*E +: 2*E] = sub_i ? (ax - bx) : (ax + bx);
    end
  end

  always_comb begin
    res_o = '0;
    for (int s = 0; s < NSZ; s++)
      if (int'(size_i) == s) res_o = res_v[s];
  end
endmodule

// File: rtl/simd_widen_unit.sv
module simd_widen_unit
  import simd_widen_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      insn_i,
  input  logic             regs32_i,
  input  logic             fp_en_i,
  output logic [IDX_W-1:0] rd_a_idx_o,
  input  logic [W-1:0]     rd_a_data_i,
  output logic [IDX_W-1:0] rd_b_idx_o,
  input  logic [W-1:0]     rd_b_data_i,
  output logic             we_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [W-1:0]     wr_data_o,
  output logic             done_o,
  output logic             undef_o,
  output logic             fault_o
);
  localparam int unsigned H = W / 2;

  state_e       state_q;
  dec_t         dec, dec_q;
  logic         fault_q;
  logic [W-1:0] a0_q, a1_q, b_q;
  logic [W-1:0] res [2];

  simd_widen_decode u_dec (
    .insn_i   (insn_i),
    .regs32_i (regs32_i),
    .dec_o    (dec)
  );

  for (genvar p = 0; p < 2; p++) begin : g_pass
    simd_widen_alu #(.W(W)) u_alu (
      .a_wide_i (p == 0 ? a0_q : a1_q),
      .a_nar_i  (a0_q[p*H +: H]),
      .b_nar_i  (b_q[p*H +: H]),
      .size_i   (dec_q.size),
      .uns_i    (dec_q.uns),
      .sub_i    (dec_q.sub),
      .wide_i   (dec_q.wide),
      .res_o    (res[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dec_q   <= '0;
      fault_q <= 1'b0;
      a0_q    <= '0;
      a1_q    <= '0;
      b_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          dec_q   <= dec;
          fault_q <= !dec.undef && !fp_en_i;
          state_q <= (dec.undef || !fp_en_i) ? ST_DONE : ST_RD0;
        end
        ST_RD0: begin
          a0_q    <= rd_a_data_i;
          b_q     <= rd_b_data_i;
          state_q <= ST_RD1;
        end
        ST_RD1: begin
          // all pass-1 operands are held before the first write
          a1_q    <= rd_a_data_i;
          state_q <= ST_WR0;
        end
        ST_WR0:  state_q <= ST_WR1;
        ST_WR1:  state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_a_idx_o = (state_q == ST_RD1) ? {dec_q.vn[IDX_W-1:1], 1'b1} : dec_q.vn;
  assign rd_b_idx_o = dec_q.vm;
  assign we_o       = (state_q == ST_WR0) || (state_q == ST_WR1);
  assign wr_idx_o   = (state_q == ST_WR1) ? {dec_q.vd[IDX_W-1:1], 1'b1} : dec_q.vd;
  assign wr_data_o  = (state_q == ST_WR1) ? res[1] : res[0];
  assign done_o     = (state_q == ST_DONE);
  assign undef_o    = done_o && dec_q.undef;
  assign fault_o    = done_o && fault_q;
endmodule

// File: rtl/simd_widen_chk.sv
module simd_widen_chk #(
  parameter int unsigned IW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_o,
  input logic [IW-1:0] wr_idx_o,
  input logic          done_o,
  input logic          undef_o,
  input logic          fault_o
);
  assert_even_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && !$past(we_o) |-> !wr_idx_o[0]);

  assert_pair_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && $past(we_o) |-> wr_idx_o == $past(wr_idx_o) + 1'b1);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_write_undef_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !we_o && !$past(we_o));

  assert_no_write_fault_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !we_o && !$past(we_o) && !undef_o);

  assert_flag_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || fault_o) |-> done_o);
endmodule

bind simd_widen_unit simd_widen_chk #(.IW(simd_widen_pkg::IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_o     (we_o),
  .wr_idx_o (wr_idx_o),
  .done_o   (done_o),
  .undef_o  (undef_o),
  .fault_o  (fault_o)
);

// File: tb/simd_widen_unit_tb.sv
module simd_widen_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic        regs32 = 1'b1;
  logic        fp_en = 1'b1;
  logic [4:0]  ra_idx, rb_idx, w_idx;
  logic [63:0] ra_dat, rb_dat, w_dat;
  logic        we, done, undef, fault;

  logic [63:0] rf [32];
  logic        ld_en = 1'b0;
  logic [4:0]  ld_idx = '0;
  logic [63:0] ld_dat = '0;
  int unsigned wcnt = 0;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  simd_widen_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insn_i(insn),
    .regs32_i(regs32), .fp_en_i(fp_en),
    .rd_a_idx_o(ra_idx), .rd_a_data_i(ra_dat),
    .rd_b_idx_o(rb_idx), .rd_b_data_i(rb_dat),
    .we_o(we), .wr_idx_o(w_idx), .wr_data_o(w_dat),
    .done_o(done), .undef_o(undef), .fault_o(fault)
  );

  assign ra_dat = rf[ra_idx];
  assign rb_dat = rf[rb_idx];

  always @(posedge clk) begin
    if (ld_en) rf[ld_idx] <= ld_dat;
    else if (we) begin
      rf[w_idx] <= w_dat;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit u, input logic [1:0] sz, input logic [1:0] op,
                                     input logic [4:0] vd, input logic [4:0] vn, input logic [4:0] vm);
    return {7'b1111001, u, 1'b1, vd[4], sz, vn[3:0], vd[3:0], 2'b00, op,
            vn[4], 1'b0, vm[4], 1'b0, vm[3:0]};
  endfunction

  function automatic logic [63:0] lmask(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] aw, input logic [31:0] an, input logic [31:0] bn,
                                        input int sz, input bit u, input bit sub, input bit wide);
    int e = 8 << sz;
    int w = 2 * e;
    logic [63:0] r = '0;
    for (int i = 0; i < 32 / e; i++) begin
      logic [63:0] bx, ax, y;
      bx = (64'(bn) >> (i * e)) & lmask(e);
      if (!u && bx[e-1]) bx = bx | (lmask(w) ^ lmask(e));
      if (wide) ax = (aw >> (i * w)) & lmask(w);
      else begin
        ax = (64'(an) >> (i * e)) & lmask(e);
        if (!u && ax[e-1]) ax = ax | (lmask(w) ^ lmask(e));
      end
      y = (sub ? ax - bx : ax + bx) & lmask(w);
      r = r | (y << (i * w));
    end
    return r;
  endfunction

  // fill: 0 random, 1 all ones, 2 sign-boundary pattern
  task automatic do_op(input logic [31:0] w, input bit fp, input bit r32, input int fill,
                       input bit restart, input string tag);
    logic [63:0] old [32];
    logic [63:0] exp [32];
    bit match, undf, flt, wide, sub, u;
    logic [4:0] vd, vn, vm;
    int sz, lat, exp_lat, mism;
    int unsigned w0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      old[i] = (fill == 1) ? '1 : (fill == 2) ? 64'h7F80_8000_FF01_807F : {$urandom, $urandom};
      ld_en = 1'b1; ld_idx = 5'(i); ld_dat = old[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    regs32 = r32; fp_en = fp;

    match = (w[31:25] == 7'b1111001) && w[23] && (w[11:10] == 2'b00) && !w[6] && !w[4];
    u = w[24]; sz = int'(w[21:20]); wide = w[8]; sub = w[9];
    vd = {w[22], w[15:12]}; vn = {w[7], w[19:16]}; vm = {w[5], w[3:0]};
    undf = !match || sz == 3 || vd[0] || (wide && vn[0]) || (!r32 && (vd[4] || vn[4] || vm[4]));
    flt = !undf && !fp;
    for (int i = 0; i < 32; i++) exp[i] = old[i];
    if (!undf && fp) begin
      exp[vd] = model(old[vn], old[vn][31:0], old[vm][31:0], sz, u, sub, wide);
      exp[vd | 5'd1] = model(wide ? old[vn | 5'd1] : '0, old[vn][63:32], old[vm][63:32], sz, u, sub, wide);
    end
    exp_lat = (undf || flt) ? 1 : 5;

    w0 = wcnt;
    insn = w; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (restart && lat == 2) begin
        start = 1'b1;
        insn = mk(1'b0, 2'b00, 2'b00, vd ^ 5'd2, vn, vm);
      end
    end while (!done && lat < 20);
    start = 1'b0;
    chk(lat == exp_lat, {tag, " R8 latency"}, 64'(lat), 64'(exp_lat));
    chk(undef == undf, {tag, " R10 undef"}, 64'(undef), 64'(undf));
    chk(fault == flt, {tag, " R11 fault"}, 64'(fault), 64'(flt));
    repeat (4) @(negedge clk);
    chk(!done, {tag, " R12 no rerun"}, 64'(done), 64'd0);
    chk(wcnt - w0 == ((undf || flt) ? 0 : 2), {tag, " R8 write count"}, 64'(wcnt - w0),
        64'((undf || flt) ? 0 : 2));
    mism = -1;
    for (int i = 0; i < 32; i++) if (mism < 0 && rf[i] !== exp[i]) mism = i;
    chk(mism < 0, $sformatf("%s R5 R6 R9 reg %0d", tag, mism < 0 ? 0 : mism),
        mism < 0 ? '0 : rf[mism], mism < 0 ? '0 : exp[mism]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !we && !undef && !fault, "reset outputs quiet R8",
        {60'd0, done, we, undef, fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !we, "post-reset idle R8", {62'd0, done, we}, 64'd0);

    // R2 R5 R6 R7: sweep every sign/op/size with random indices (some illegal)
    for (int u = 0; u < 2; u++)
      for (int op = 0; op < 4; op++)
        for (int sz = 0; sz < 4; sz++)
          for (int t = 0; t < 4; t++) begin
            logic [4:0] vd, vn, vm;
            vd = 5'($urandom); vn = 5'($urandom); vm = 5'($urandom);
            if (t < 3) begin vd[0] = 1'b0; vn[0] = 1'b0; end
            do_op(mk(1'(u), 2'(sz), 2'(op), vd, vn, vm), 1'b1, 1'b1, (t == 1) ? 1 : (t == 2) ? 2 : 0,
                  1'b0, $sformatf("R7 sweep u%0d op%0d sz%0d", u, op, sz));
          end

    // R3: odd destination, odd wide source, odd long source (legal)
    do_op(mk(1'b0, 2'b01, 2'b00, 5'd3, 5'd4, 5'd6), 1'b1, 1'b1, 0, 1'b0, "R3 odd vd");
    do_op(mk(1'b1, 2'b00, 2'b01, 5'd2, 5'd5, 5'd6), 1'b1, 1'b1, 0, 1'b0, "R3 odd wide vn");
    do_op(mk(1'b1, 2'b00, 2'b10, 5'd2, 5'd5, 5'd7), 1'b1, 1'b1, 0, 1'b0, "R3 odd long vn ok");

    // R1: corrupt each fixed opcode bit
    for (int b = 0; b < 32; b++)
      if ((b >= 25) || b == 23 || b == 11 || b == 10 || b == 6 || b == 4)
        do_op(mk(1'b0, 2'b10, 2'b00, 5'd8, 5'd10, 5'd12) ^ (32'd1 << b), 1'b1, 1'b1, 0, 1'b0,
              $sformatf("R1 bit %0d", b));

    // R4: 16-register mode
    do_op(mk(1'b0, 2'b00, 2'b00, 5'd18, 5'd2, 5'd4), 1'b1, 1'b0, 0, 1'b0, "R4 vd high");
    do_op(mk(1'b0, 2'b00, 2'b00, 5'd2, 5'd20, 5'd4), 1'b1, 1'b0, 0, 1'b0, "R4 vn high");
    do_op(mk(1'b0, 2'b00, 2'b00, 5'd2, 5'd4, 5'd17), 1'b1, 1'b0, 0, 1'b0, "R4 vm high");
    do_op(mk(1'b0, 2'b01, 2'b11, 5'd14, 5'd12, 5'd15), 1'b1, 1'b0, 0, 1'b0, "R4 low ok");

    // R9: overlap of destination with sources
    for (int op = 0; op < 4; op++)
      for (int sz = 0; sz < 3; sz++) begin
        do_op(mk(1'b0, 2'(sz), 2'(op), 5'd6, 5'd6, 5'd9), 1'b1, 1'b1, 0, 1'b0, "R9 vd=vn");
        do_op(mk(1'b1, 2'(sz), 2'(op), 5'd10, 5'd2, 5'd10), 1'b1, 1'b1, 0, 1'b0, "R9 vd=vm");
        do_op(mk(1'b0, 2'(sz), 2'(op), 5'd20, 5'd24, 5'd21), 1'b1, 1'b1, 0, 1'b0, "R9 vd+1=vm");
        do_op(mk(1'b1, 2'(sz), 2'(op), 5'd30, 5'd30, 5'd30), 1'b1, 1'b1, 0, 1'b0, "R9 all same");
      end

    // R11: unit disabled; undef beats fault
    do_op(mk(1'b0, 2'b01, 2'b01, 5'd4, 5'd6, 5'd8), 1'b0, 1'b1, 0, 1'b0, "R11 disabled");
    do_op(mk(1'b0, 2'b11, 2'b01, 5'd4, 5'd6, 5'd8), 1'b0, 1'b1, 0, 1'b0, "R11 undef priority");

    // R12: start pulsed mid-operation is ignored
    do_op(mk(1'b1, 2'b10, 2'b11, 5'd12, 5'd14, 5'd3), 1'b1, 1'b1, 0, 1'b1, "R12 restart");
    do_op(mk(1'b0, 2'b00, 2'b00, 5'd0, 5'd1, 5'd31), 1'b1, 1'b1, 2, 1'b1, "R12 restart long");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule